// File: doc/BRIEF.md
# Audio Receive Frame Sync Unit

This unit is the receive-side frame sync path of a serial audio port working in I2S or two-slot TDM framing. It either builds the frame sync itself from the receive bit clock or accepts one arriving on a pad. When the pad is an output, the unit drives it. Whatever the source, the chosen signal passes through exactly one selectable inverter, so that a frame always begins on a rising edge inside the block. That rising edge becomes a one-cycle frame-start strobe.

From that strobe the unit counts bit clocks. It raises an MSB strobe once the programmed data delay has elapsed, and it then reports the slot index and the bit index within the slot, so that a neighbouring shifter knows which bit it is capturing. A pad-loopback option makes an internally generated sync return through the pad input. The sync then sees the same buffer delay as the incoming data.

All configuration inputs are static. They may change only while `rstN` holds the receiver in reset. The unit runs entirely on the receive bit clock `clk`.

Top module: `rxFrameSyncUnit`

## Requirements
- R1: While `rstN` is low, `frameStart`, `msbStrobe` and `dataValid` are 0, and `fsPinOut` sits at its inactive level, which equals `cfgPolarity`.
- R2: With `cfgPolarity`=0 a low-to-high transition of the selected sync line starts a frame; with `cfgPolarity`=1 a high-to-low transition does. `frameStart` is a one-cycle pulse in the cycle that follows the rising `clk` edge that first samples the new line level.
- R3: `cfgInternal`=1 with `cfgLoopback`=0 selects the generated sync (the level on `fsPinOut`) as the selected line; `cfgInternal`=0 selects `fsPinIn`.
- R4: `cfgInternal`=1 with `cfgLoopback`=1 selects `fsPinIn` as the line, so the generated sync re-enters through the pad. The line is inverted exactly once, by `cfgPolarity`, on every path.
- R5: `fsPinOe` equals `cfgPinOut` (1 = the unit drives the sync pad).
- R6: The generator holds the active level for the first slot of `cfgSlotBitsM1`+1 bit clocks and the inactive level for the second slot. A full frame is therefore 2·(`cfgSlotBitsM1`+1) bit clocks. `fsPinOut` changes only on the falling edge of `clk`.
- R7: `msbStrobe` is asserted exactly `cfgDataDelay` cycles after each `frameStart` (0, 1 or 2; 1 is the I2S convention). With delay 0 it coincides with `frameStart`.
- R8: Starting at the `msbStrobe` cycle, `dataValid` is 1. `bitIndex` counts 0..`cfgSlotBitsM1` and then wraps to 0. `slotIndex` starts at 0 and advances by one at each wrap, modulo 2. Each `msbStrobe` restarts both at 0.
- R9: The configuration inputs hold steady while `rstN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rstN | input | 1 | Active-low asynchronous reset of the receiver |
| cfgPolarity | input | 1 | 0: rising edge starts a frame; 1: falling edge |
| cfgInternal | input | 1 | 1: generate the sync internally; 0: take it from the pad |
| cfgPinOut | input | 1 | 1: drive the sync pad |
| cfgLoopback | input | 1 | 1: return the generated sync through the pad input |
| cfgDataDelay | input | clog2(MAX_DELAY+1) (2) | Bit clocks from frame start to MSB |
| cfgSlotBitsM1 | input | clog2(MAX_SLOT_BITS) (5) | Bits per slot minus one |
| fsPinIn | input | 1 | Sync pad input buffer |
| fsPinOut | output | 1 | Sync pad output value |
| fsPinOe | output | 1 | Sync pad output enable |
| frameStart | output | 1 | One-cycle frame-start strobe |
| msbStrobe | output | 1 | First data bit of the frame |
| dataValid | output | 1 | Slot and bit indices are meaningful |
| slotIndex | output | clog2(NUM_SLOTS) (1) | Current slot |
| bitIndex | output | clog2(MAX_SLOT_BITS) (5) | Bit position within the slot |

## Verification
A polarity error or a second inversion in the sync path moves `frameStart` by half a frame. The first mismatch then appears within one frame after reset, and `msbStrobe` and both indices are displaced from then on. A wrong source selection shows as `frameStart` following the external pattern instead of the generator, or the reverse, which is visible within two frames. An off-by-one in the delay or slot counters shows at the first `msbStrobe` or at the first slot boundary, no more than one slot after it.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic frameStart;
    logic msbNow;
    logic bitWrap;
  } rxfsStrobes_t;
endpackage

// File: rtl/rxfsDatapath.sv
module rxfsDatapath
  import rxfs_pkg::*;
#(
  parameter int MAX_SLOT_BITS = 32,
  parameter int NUM_SLOTS = 2,
  parameter int MAX_DELAY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgPolarity,
  input  logic cfgInternal,
  input  logic cfgPinOut,
  input  logic cfgLoopback,
  input  logic [$clog2(MAX_SLOT_BITS)-1:0] cfgSlotBitsM1,
  input  logic fsPinIn,
  input  rxfsStrobes_t strobes,
  output logic fsPinOut,
  output logic fsPinOe,
  output logic normCap,
  output logic normPrev,
  output logic [$clog2(MAX_DELAY+1):0] posReg,
  output logic posValid,
  output logic [$clog2(MAX_SLOT_BITS)-1:0] bitReg,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIndex,
  output logic [$clog2(MAX_SLOT_BITS)-1:0] bitIndex,
  output logic dataValid
);
  localparam int SB_W = $clog2(MAX_SLOT_BITS);
  localparam int SL_W = $clog2(NUM_SLOTS);
  localparam int POS_W = $clog2(MAX_DELAY+1) + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam bit IS_POW2 = (NUM_SLOTS & (NUM_SLOTS - 1)) == 0;

  logic [SB_W-1:0] genBit;
  logic [SL_W-1:0] genSlot, genSlotNext;
  logic [SL_W-1:0] slotReg, baseSlot, slotAfter;
  logic [SB_W-1:0] baseBit;
  logic pinRaw, selLine, dataRun;

  assign baseSlot = strobes.msbNow ? '0 : slotReg;
  assign baseBit  = strobes.msbNow ? '0 : bitReg;

  generate
    if (IS_POW2) begin : gSlotPow2
      assign genSlotNext = genSlot + 1'b1;
      assign slotAfter   = baseSlot + 1'b1;
    end else begin : gSlotCmp
      assign genSlotNext = (genSlot == SL_W'(NUM_SLOTS-1)) ? '0 : genSlot + 1'b1;
      assign slotAfter   = (baseSlot == SL_W'(NUM_SLOTS-1)) ? '0 : baseSlot + 1'b1;
    end
  endgenerate

  // frame sync generator on the bit clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genBit  <= '0;
      genSlot <= '0;
    end else if (genBit == cfgSlotBitsM1) begin
      genBit  <= '0;
      genSlot <= genSlotNext;
    end else begin
      genBit <= genBit + 1'b1;
    end
  end

  // pad launch on the falling bit clock edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) pinRaw <= 1'b0;
    else       pinRaw <= (genSlot == '0);
  end

  assign fsPinOut = pinRaw ^ cfgPolarity;
  assign fsPinOe  = cfgPinOut;

  // source select, then the single polarity inverter
  assign selLine = (cfgInternal && !cfgLoopback) ? fsPinOut : fsPinIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normCap  <= 1'b0;
      normPrev <= 1'b0;
    end else begin
      normCap  <= selLine ^ cfgPolarity;
      normPrev <= normCap;
    end
  end

  // bit clocks since the last frame start, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posReg   <= '0;
      posValid <= 1'b0;
    end else if (strobes.frameStart) begin
      posReg   <= POS_W'(1);
      posValid <= 1'b1;
    end else if (posValid && posReg != POS_MAX) begin
      posReg <= posReg + 1'b1;
    end
  end

  // slot and bit position of the data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitReg  <= '0;
      slotReg <= '0;
      dataRun <= 1'b0;
    end else if (strobes.msbNow || dataRun) begin
      dataRun <= 1'b1;
      if (strobes.bitWrap) begin
        bitReg  <= '0;
        slotReg <= slotAfter;
      end else begin
        bitReg  <= baseBit + 1'b1;
        slotReg <= baseSlot;
      end
    end
  end

  assign slotIndex = baseSlot;
  assign bitIndex  = baseBit;
  assign dataValid = strobes.msbNow | dataRun;
endmodule

// File: rtl/rxfsControl.sv
module rxfsControl
  import rxfs_pkg::*;
#(
  parameter int MAX_SLOT_BITS = 32,
  parameter int MAX_DELAY = 2
) (
  input  logic [$clog2(MAX_DELAY+1)-1:0] cfgDataDelay,
  input  logic [$clog2(MAX_SLOT_BITS)-1:0] cfgSlotBitsM1,
  input  logic normCap,
  input  logic normPrev,
  input  logic [$clog2(MAX_DELAY+1):0] posReg,
  input  logic posValid,
  input  logic [$clog2(MAX_SLOT_BITS)-1:0] bitReg,
  output rxfsStrobes_t strobes
);
  localparam int POS_W = $clog2(MAX_DELAY+1) + 1;

  logic fsEdge, validEff, msbHit;
  logic [POS_W-1:0] posEff;

  assign fsEdge   = normCap & ~normPrev;
  assign posEff   = fsEdge ? '0 : posReg;
  assign validEff = fsEdge | posValid;
  assign msbHit   = validEff && (posEff == {1'b0, cfgDataDelay});

  always_comb begin
    strobes.frameStart = fsEdge;
    strobes.msbNow     = msbHit;
    strobes.bitWrap    = (msbHit ? '0 : bitReg) == cfgSlotBitsM1;
  end
endmodule

// File: rtl/rxFrameSyncUnit.sv
module rxFrameSyncUnit
  import rxfs_pkg::*;
#(
  parameter int MAX_SLOT_BITS = 32,
  parameter int NUM_SLOTS = 2,
  parameter int MAX_DELAY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgPolarity,
  input  logic cfgInternal,
  input  logic cfgPinOut,
  input  logic cfgLoopback,
  input  logic [$clog2(MAX_DELAY+1)-1:0] cfgDataDelay,
  input  logic [$clog2(MAX_SLOT_BITS)-1:0] cfgSlotBitsM1,
  input  logic fsPinIn,
  output logic fsPinOut,
  output logic fsPinOe,
  output logic frameStart,
  output logic msbStrobe,
  output logic dataValid,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIndex,
  output logic [$clog2(MAX_SLOT_BITS)-1:0] bitIndex
);
  localparam int SB_W = $clog2(MAX_SLOT_BITS);
  localparam int POS_W = $clog2(MAX_DELAY+1) + 1;

  rxfsStrobes_t strobes;
  logic normCap, normPrev, posValid;
  logic [POS_W-1:0] posReg;
  logic [SB_W-1:0] bitReg;

  rxfsDatapath #(
    .MAX_SLOT_BITS(MAX_SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .MAX_DELAY(MAX_DELAY)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .cfgPolarity(cfgPolarity), .cfgInternal(cfgInternal),
    .cfgPinOut(cfgPinOut), .cfgLoopback(cfgLoopback),
    .cfgSlotBitsM1(cfgSlotBitsM1), .fsPinIn(fsPinIn), .strobes(strobes),
    .fsPinOut(fsPinOut), .fsPinOe(fsPinOe),
    .normCap(normCap), .normPrev(normPrev),
    .posReg(posReg), .posValid(posValid), .bitReg(bitReg),
    .slotIndex(slotIndex), .bitIndex(bitIndex), .dataValid(dataValid)
  );

  rxfsControl #(
    .MAX_SLOT_BITS(MAX_SLOT_BITS), .MAX_DELAY(MAX_DELAY)
  ) uCtl (
    .cfgDataDelay(cfgDataDelay), .cfgSlotBitsM1(cfgSlotBitsM1),
    .normCap(normCap), .normPrev(normPrev),
    .posReg(posReg), .posValid(posValid), .bitReg(bitReg),
    .strobes(strobes)
  );

  assign frameStart = strobes.frameStart;
  assign msbStrobe  = strobes.msbNow;
endmodule

// File: rtl/rxfsChecker.sv
module rxfsChecker #(
  parameter int MAX_SLOT_BITS = 32,
  parameter int NUM_SLOTS = 2,
  parameter int MAX_DELAY = 2
) (
  input logic clk,
  input logic rstN,
  input logic cfgPolarity,
  input logic cfgInternal,
  input logic cfgLoopback,
  input logic [$clog2(MAX_DELAY+1)-1:0] cfgDataDelay,
  input logic [$clog2(MAX_SLOT_BITS)-1:0] cfgSlotBitsM1,
  input logic frameStart,
  input logic msbStrobe,
  input logic dataValid,
  input logic [$clog2(NUM_SLOTS)-1:0] slotIndex,
  input logic [$clog2(MAX_SLOT_BITS)-1:0] bitIndex
);
  localparam int CNT_W = $clog2(MAX_DELAY+1) + 2;
  logic [CNT_W-1:0] since, sinceEff;
  logic seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (frameStart) begin
      since <= CNT_W'(1);
      seen  <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  assign sinceEff = frameStart ? '0 : since;

  // R7: MSB lands exactly the data delay after the frame start
  assert_msb_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    msbStrobe |-> ((seen || frameStart) && sinceEff == CNT_W'(cfgDataDelay)));
  assert_msb_zero_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && cfgDataDelay == '0) |-> msbStrobe);
  // R2: the frame-start strobe lasts one cycle
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  // R8: bit index steps and slot wraps
  assert_bit_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataValid) && !msbStrobe && $past(bitIndex) != cfgSlotBitsM1)
      |-> (bitIndex == $past(bitIndex) + 1'b1));
  assert_slot_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataValid) && !msbStrobe && $past(bitIndex) == cfgSlotBitsM1)
      |-> (bitIndex == '0 && slotIndex != $past(slotIndex)));
  // R9: configuration frozen outside reset
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(cfgPolarity) && $stable(cfgInternal) &&
                     $stable(cfgLoopback) && $stable(cfgDataDelay) &&
                     $stable(cfgSlotBitsM1)));
endmodule

bind rxFrameSyncUnit rxfsChecker #(
  .MAX_SLOT_BITS(MAX_SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .MAX_DELAY(MAX_DELAY)
) uChk (
  .clk(clk), .rstN(rstN), .cfgPolarity(cfgPolarity), .cfgInternal(cfgInternal),
  .cfgLoopback(cfgLoopback), .cfgDataDelay(cfgDataDelay),
  .cfgSlotBitsM1(cfgSlotBitsM1), .frameStart(frameStart),
  .msbStrobe(msbStrobe), .dataValid(dataValid),
  .slotIndex(slotIndex), .bitIndex(bitIndex)
);

// File: tb/sim_rxFrameSyncUnit.sv
module sim_rxFrameSyncUnit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPolarity = 1'b0, cfgInternal = 1'b0, cfgPinOut = 1'b0, cfgLoopback = 1'b0;
  logic [1:0] cfgDataDelay = '0;
  logic [4:0] cfgSlotBitsM1 = 5'd1;
  logic extDrive = 1'b0;
  logic fsPinIn, fsPinOut, fsPinOe, frameStart, msbStrobe, dataValid;
  logic [0:0] slotIndex;
  logic [4:0] bitIndex;

  int vectors = 0;
  int miscompares = 0;

  // pad model: driven value returns through the input buffer
  assign fsPinIn = fsPinOe ? fsPinOut : extDrive;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxFrameSyncUnit u0 (
    .clk(clk), .rstN(rstN), .cfgPolarity(cfgPolarity), .cfgInternal(cfgInternal),
    .cfgPinOut(cfgPinOut), .cfgLoopback(cfgLoopback), .cfgDataDelay(cfgDataDelay),
    .cfgSlotBitsM1(cfgSlotBitsM1), .fsPinIn(fsPinIn), .fsPinOut(fsPinOut),
    .fsPinOe(fsPinOe), .frameStart(frameStart), .msbStrobe(msbStrobe),
    .dataValid(dataValid), .slotIndex(slotIndex), .bitIndex(bitIndex)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // reference model state
  bit ln, rs, pinEdge, mCur, mPrev, expFs, expMsb, sinceV, dv, genDrives;
  int since, msbCnt, fsCount, cyc, hiCnt, w;

  always begin
    @(posedge clk);
    ln = (cfgInternal && !cfgLoopback) ? fsPinOut : fsPinIn;
    rs = rstN;
    pinEdge = fsPinOut;
    #2;
    w = int'(cfgSlotBitsM1) + 1;
    genDrives = cfgInternal && (!cfgLoopback || cfgPinOut);
    if (!rs) begin
      mCur = 0; mPrev = 0; sinceV = 0; since = 0; dv = 0; msbCnt = 0;
      fsCount = 0; cyc = 0; hiCnt = 0;
      chk(frameStart == 1'b0, "R1 frameStart in reset", int'(frameStart), 0);
      chk(msbStrobe == 1'b0, "R1 msbStrobe in reset", int'(msbStrobe), 0);
      chk(dataValid == 1'b0, "R1 dataValid in reset", int'(dataValid), 0);
      chk(fsPinOut == cfgPolarity, "R1 pad idle level", int'(fsPinOut), int'(cfgPolarity));
    end else begin
      mPrev = mCur;
      mCur = ln ^ cfgPolarity;
      expFs = mCur && !mPrev;
      if (expFs) begin sinceV = 1; since = 0; end
      else if (sinceV) since++;
      expMsb = sinceV && (since == int'(cfgDataDelay));
      if (expMsb) begin dv = 1; msbCnt = 0; end
      else if (dv) msbCnt++;
      if (!cfgInternal)
        chk(frameStart == expFs, "R3 frameStart from pad", int'(frameStart), int'(expFs));
      else if (cfgLoopback)
        chk(frameStart == expFs, "R4 frameStart via loopback", int'(frameStart), int'(expFs));
      else
        chk(frameStart == expFs, "R2 frameStart from generator", int'(frameStart), int'(expFs));
      chk(msbStrobe == expMsb, "R7 msbStrobe", int'(msbStrobe), int'(expMsb));
      chk(dataValid == dv, "R8 dataValid", int'(dataValid), int'(dv));
      if (dv) begin
        chk(int'(bitIndex) == msbCnt % w, "R8 bitIndex", int'(bitIndex), msbCnt % w);
        chk(int'(slotIndex) == (msbCnt / w) % 2, "R8 slotIndex", int'(slotIndex), (msbCnt / w) % 2);
      end
      chk(fsPinOe == cfgPinOut, "R5 pad enable", int'(fsPinOe), int'(cfgPinOut));
      if (cfgInternal) begin
        chk(fsPinOut == pinEdge, "R6 pad steady across rising edge", int'(fsPinOut), int'(pinEdge));
      end
      if (expFs) begin
        if (fsCount >= 2 && genDrives) begin
          chk(cyc == 2 * w, "R6 frame length", cyc, 2 * w);
          chk(hiCnt == w, "R6 active slot length", hiCnt, w);
        end
        fsCount++; cyc = 0; hiCnt = 0;
      end
      cyc++;
      if (mCur) hiCnt++;
    end
  end

  task automatic runConfig(input int mode, input bit pol, input int dly, input int wid);
    int runLen;
    @(posedge clk); #3;
    rstN = 1'b0;
    cfgPolarity = pol;
    cfgDataDelay = 2'(dly);
    cfgSlotBitsM1 = 5'(wid - 1);
    // modes: 0 pad in, 1 generator + pad out, 2 generator pad off,
    //        3 loopback pad out, 4 loopback pad off (pad follows outside)
    cfgInternal = (mode != 0);
    cfgLoopback = (mode >= 3);
    cfgPinOut = (mode == 1 || mode == 3);
    extDrive = pol;
    repeat (3) @(posedge clk);
    #3;
    rstN = 1'b1;
    runLen = 8 * wid + 12;
    for (int c = 0; c < runLen; c++) begin
      extDrive = ((((c + mode + dly) % (2 * wid)) < wid) ? 1'b1 : 1'b0) ^ pol;
      @(posedge clk); #3;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    for (int m = 0; m < 5; m++)
      for (int p = 0; p < 2; p++)
        for (int d = 0; d < 3; d++)
          for (int wv = 2; wv <= 4; wv++)
            runConfig(m, p[0], d, (wv == 4) ? 5 : wv);
    @(posedge clk); #3;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #4;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule